// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave holds low because it stopped partway through a byte. On a start request it takes the two bus pins away from the normal byte controller and drives them by hand. First it releases SDA and toggles SCL nine times, so the slave can clock out whatever bits it still owes. Then it builds a stop condition one step at a time. The byte controller can start this sequence when the bus stays busy before an address phase and a short wait has run out.

Every step of the sequence lasts `HALF_CYCLES` system clocks, which is about 5 µs at the intended clock rate. There are nine pulses, each made of two steps, and four stop steps, so the run is 22 steps long. In the last cycle of the final step the sequencer samples the SDA line. It then hands the pins back to the byte controller, raises `done` for one cycle, and sets `busyErr` if SDA was still low. Pin levels use 1 for released (high) and 0 for pulled low.

Top module: `i2c_unjam`

## Requirements
- R1: After reset `active`, `done` and `busyErr` are 0, and `sclLevel`/`sdaLevel` equal `ctlScl`/`ctlSda`.
- R2: While no recovery runs, `sclLevel` follows `ctlScl` and `sdaLevel` follows `ctlSda` in the same cycle.
- R3: The clock edge that samples `start` high while idle begins step 0. From that edge `active` is 1, and step k runs from k*HALF_CYCLES to (k+1)*HALF_CYCLES-1 cycles after it.
- R4: Steps 0 to 17 form nine SCL pulses with SDA at 1. In even steps SCL is 1 and in odd steps SCL is 0, so there are nine SCL falling edges.
- R5: Steps 18 to 21 build the stop in this order of (SCL,SDA): (0,1), (0,0), (1,0), (1,1).
- R6: While the sequencer drives the pins, SCL and SDA never change in the same cycle.
- R7: Exactly 22*HALF_CYCLES cycles after the start edge, `done` is 1 for one cycle. In that same cycle `active` is 0 and the pins follow the controller inputs again.
- R8: `busyErr` is set when `sdaIn` was 0 in the last cycle of step 21. It is cleared when a new run starts and otherwise holds its value.
- R9: A `start` pulse during a run has no effect on the pin sequence or on the time at which `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a recovery run (taken only while idle) |
| sdaIn | input | 1 | Sampled level of the SDA line |
| ctlScl | input | 1 | SCL level wanted by the byte controller |
| ctlSda | input | 1 | SDA level wanted by the byte controller |
| sclLevel | output | 1 | SCL pin level (1 = released) |
| sdaLevel | output | 1 | SDA pin level (1 = released) |
| active | output | 1 | Sequencer owns the pins |
| done | output | 1 | One-cycle end-of-run pulse |
| busyErr | output | 1 | SDA still low at the end of the last run |

## Verification
The bench models a stuck slave that holds SDA low until it has seen a chosen number of SCL falling edges. It sweeps that number from zero to nine, and also covers a slave that never lets go. In each run it compares the full pin trace with a step table computed from the cycle count. The runs that release within nine edges must end without an error, while the slave that never releases must raise `busyErr`. Together these show that exactly nine edges are produced and that SDA is sampled in the right cycle. A second start pulse in the middle of a run, and controller-level patterns applied while idle, check that the sequencer ignores a second start and hands the pins back correctly.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;
  typedef struct packed {
    logic load;    // apply new step levels and restart the step timer
    logic clrErr;  // new run accepted: clear the error flag
    logic sclLvl;  // SCL level for the step being loaded
    logic sdaLvl;  // SDA level for the step being loaded
    logic finish;  // last step elapsed: sample SDA, release pins
  } unjamStrobe_t;
endpackage

// File: rtl/i2c_unjam_ctrl.sv
module i2c_unjam_ctrl
  import i2c_unjam_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         timerZero,
  output unjamStrobe_t strobe
);
  localparam int NSTEPS = 2 * PULSES + 4;
  localparam int SW     = $clog2(NSTEPS);
  localparam logic [SW-1:0] LAST = SW'(NSTEPS - 1);

  logic          running;
  logic [SW-1:0] stepIdx;
  logic [SW-1:0] nextIdx;

  function automatic logic [1:0] stepLevels(input logic [SW-1:0] idx);
    logic [1:0] lv;
    if (int'(idx) < 2 * PULSES) begin
      lv = {~idx[0], 1'b1};
    end else begin
      case (int'(idx) - 2 * PULSES)
        0:       lv = 2'b01;
        1:       lv = 2'b00;
        2:       lv = 2'b10;
        default: lv = 2'b11;
      endcase
    end
    return lv;
  endfunction

  always_comb begin
    strobe  = '0;
    nextIdx = stepIdx;
    if (!running) begin
      if (start) begin
        nextIdx       = '0;
        strobe.load   = 1'b1;
        strobe.clrErr = 1'b1;
        {strobe.sclLvl, strobe.sdaLvl} = stepLevels('0);
      end
    end else if (timerZero) begin
      if (stepIdx == LAST) begin
        strobe.finish = 1'b1;
      end else begin
        nextIdx     = stepIdx + 1'b1;
        strobe.load = 1'b1;
        {strobe.sclLvl, strobe.sdaLvl} = stepLevels(stepIdx + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      stepIdx <= '0;
    end else begin
      stepIdx <= nextIdx;
      if (strobe.finish)                 running <= 1'b0;
      else if (!running && strobe.load)  running <= 1'b1;
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (running && timerZero && stepIdx != LAST) |=> (stepIdx == $past(stepIdx) + 1'b1)); // R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= LAST); // R5

  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (running && !timerZero) |=> (stepIdx == $past(stepIdx))); // R9
endmodule

// File: rtl/i2c_unjam_dp.sv
module i2c_unjam_dp
  import i2c_unjam_pkg::*;
#(
  parameter int HALF_CYCLES = 250
) (
  input  logic         clk,
  input  logic         rstN,
  input  unjamStrobe_t strobe,
  input  logic         sdaIn,
  input  logic         ctlScl,
  input  logic         ctlSda,
  output logic         timerZero,
  output logic         sclLevel,
  output logic         sdaLevel,
  output logic         active,
  output logic         done,
  output logic         busyErr
);
  localparam int TW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [TW-1:0] TLOAD = TW'(HALF_CYCLES - 1);

  logic [TW-1:0] timer;
  logic          ovr;
  logic          sclQ;
  logic          sdaQ;

  assign timerZero = (timer == '0);
  assign sclLevel  = ovr ? sclQ : ctlScl;
  assign sdaLevel  = ovr ? sdaQ : ctlSda;
  assign active    = ovr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      ovr     <= 1'b0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      done    <= 1'b0;
      busyErr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.load) begin
        ovr   <= 1'b1;
        sclQ  <= strobe.sclLvl;
        sdaQ  <= strobe.sdaLvl;
        timer <= TLOAD;
      end else if (!timerZero) begin
        timer <= timer - 1'b1;
      end
      if (strobe.clrErr) busyErr <= 1'b0;
      if (strobe.finish) begin
        ovr     <= 1'b0;
        done    <= 1'b1;
        busyErr <= ~sdaIn;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !active); // R7

  AST_NO_DUAL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && $past(ovr)) |-> !((sclQ != $past(sclQ)) && (sdaQ != $past(sdaQ)))); // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !$past(strobe.load)) |-> $stable(busyErr)); // R8

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TLOAD); // R3
endmodule

// File: rtl/i2c_unjam.sv
module i2c_unjam
  import i2c_unjam_pkg::*;
#(
  parameter int HALF_CYCLES = 250,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic sdaIn,
  input  logic ctlScl,
  input  logic ctlSda,
  output logic sclLevel,
  output logic sdaLevel,
  output logic active,
  output logic done,
  output logic busyErr
);
  unjamStrobe_t strobe;
  logic         timerZero;

  i2c_unjam_ctrl #(.PULSES(PULSES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .timerZero(timerZero), .strobe(strobe)
  );

  i2c_unjam_dp #(.HALF_CYCLES(HALF_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaIn(sdaIn),
    .ctlScl(ctlScl), .ctlSda(ctlSda), .timerZero(timerZero),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .active(active),
    .done(done), .busyErr(busyErr)
  );
endmodule

// File: tb/i2c_unjam_test.sv
module i2c_unjam_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 3;
  localparam int NSTEPS     = 22;
  localparam int RUNLEN     = NSTEPS * H;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic ctlScl = 1'b1;
  logic ctlSda = 1'b1;
  logic slaveSda = 1'b0;
  logic sdaIn;
  logic sclLevel, sdaLevel, active, done, busyErr;

  int total = 0;
  int bad = 0;
  int fallCnt = 0;
  int relAfter = 0;
  logic prevScl = 1'b1;
  bit finished = 1'b0;

  assign sdaIn = sdaLevel & slaveSda;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_unjam #(.HALF_CYCLES(H), .PULSES(9)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sdaIn(sdaIn),
    .ctlScl(ctlScl), .ctlSda(ctlSda), .sclLevel(sclLevel),
    .sdaLevel(sdaLevel), .active(active), .done(done), .busyErr(busyErr)
  );

  // stuck slave: holds SDA low until it has seen relAfter SCL falling edges
  always @(negedge clk) begin
    if (prevScl && !sclLevel) fallCnt = fallCnt + 1;
    prevScl = sclLevel;
    if (fallCnt >= relAfter) slaveSda = 1'b1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] expLv(input int t);
    int s = t / H;
    if (s < 18) return {((s % 2) == 0) ? 1'b1 : 1'b0, 1'b1};
    if (s == 18) return 2'b01;
    if (s == 19) return 2'b00;
    if (s == 20) return 2'b10;
    return 2'b11;
  endfunction

  task automatic runOne(input int rel, input bit midStart);
    int trBad = 0;
    int falls;
    relAfter = rel;
    slaveSda = (rel == 0);
    fallCnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= RUNLEN; t++) begin
      if (t > 0) @(negedge clk);
      if (midStart && t == 10) start = 1'b1;
      if (midStart && t == 11) start = 1'b0;
      if (t == 0) check("R8 err cleared at run start", {7'd0, busyErr}, 8'd0);
      if (t < RUNLEN) begin
        if ({active, done, sclLevel, sdaLevel} !== {2'b10, expLv(t)}) begin
          trBad++;
          check(midStart ? "R9 trace with mid-run start" : "R3/R4/R5 step trace",
                {4'd0, active, done, sclLevel, sdaLevel}, {4'd0, 2'b10, expLv(t)});
        end
      end else begin
        check("R7 done at end", {6'd0, active, done}, 8'h01);
        check("R7 pins returned", {6'd0, sclLevel, sdaLevel}, {6'd0, ctlScl, ctlSda});
        check("R8 busy flag", {7'd0, busyErr}, {7'd0, (rel > 9) ? 1'b1 : 1'b0});
      end
    end
    falls = fallCnt;
    check(midStart ? "R9 whole trace" : "R4/R5 whole trace", 8'(trBad), 8'd0);
    check("R4 nine SCL falls during run", 8'(falls), 8'd9);
    @(negedge clk);
    check("R7 done lasts one cycle", {7'd0, done}, 8'd0);
    check("R8 busy flag held", {7'd0, busyErr}, {7'd0, (rel > 9) ? 1'b1 : 1'b0});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 reset outputs", {5'd0, active, done, busyErr}, 8'd0);
    check("R1 reset pins", {6'd0, sclLevel, sdaLevel}, 8'h03);
    rstN = 1'b1;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      {ctlScl, ctlSda} = 2'(p);
      #1;
      check("R2 idle passthrough", {6'd0, sclLevel, sdaLevel}, 8'(p));
      check("R2 idle inactive", {7'd0, active}, 8'd0);
    end
    ctlScl = 1'b1;
    ctlSda = 1'b1;
    for (int r = 0; r <= 10; r++) runOne(r, 1'b0);
    runOne(5, 1'b1);
    runOne(10, 1'b1);
    runOne(9, 1'b0);
    @(negedge clk);
    ctlScl = 1'b0;
    ctlSda = 1'b1;
    #1;
    check("R2 passthrough after runs", {6'd0, sclLevel, sdaLevel}, 8'h01);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule